// File: doc/BRIEF.md
# Block Address Translation Lookup

This block translates a 32-bit effective address through a small set of large-block mapping entries. The core's translation path tries it before any segment or page-table walk. Two register banks hold the entries: one for instruction fetches and one for loads and stores. Each entry is a pair of words. The upper word holds the effective block base, a length mask and two validity bits, one per privilege level. The lower word holds the real block base and a two-bit protection code.

A request carries the address, a fetch flag, a store flag and the privilege level. The lookup is combinational and the response is registered, so it appears one cycle after the request. The response reports:
- whether an entry hit;
- the translated real address;
- the read/write/execute rights;
- whether the access is granted or violates protection;
- whether the access must pass on to segment translation.

Software loads the entries through a synchronous write port.

Top module: `bat_xlate`

## Requirements
- R1: A hit requires effective address bits 31:28 to equal upper-word bits 31:28 exactly. The upper-word layout is: [31:28] block base high, [27:17] block base low, [12:2] length field, [1] supervisor valid, [0] user valid.
- R2: Effective bits 27:17 are compared with upper-word bits 27:17 only where the length field is 0. Base bits that lie under a set length bit must be 0 for the entry to match.
- R3: An entry is usable only when bit 1 is set and `req_user`=0, or when bit 0 is set and `req_user`=1.
- R4: The lower-word bits [1:0] give the rights, reported on `rsp_prot` as [0]=read, [1]=write, [2]=execute. Code 0 gives none, code 2 gives all three, and codes 1 and 3 give read and execute.
- R5: The real address is built from three parts. Bits 31:28 come from lower-word bits 31:28. Bits 27:17 are lower-word bits 27:17 ORed with the effective bits that lie under the length mask. Bits 16:0 are copied from the effective address.
- R6: A request with `req_fetch`=1 searches the instruction bank and needs execute rights. Any other request searches the data bank and needs write rights for a store or read rights for a load.
- R7: Entries are searched from index 0 upward. The first entry that matches and is usable supplies the result. An entry that matches but is unusable is skipped.
- R8: On a hit, `rsp_grant`=1 when the needed right is present and `rsp_violate`=1 otherwise. `rsp_pass`=1 whenever the access is not granted, whether it missed or was denied.
- R9: The response appears one cycle after `req_valid`. In a cycle that follows no request, `rsp_valid`, `rsp_hit`, `rsp_grant`, `rsp_violate` and `rsp_pass` are 0.
- R10: After reset every entry is 0, so no lookup hits. A write takes effect on lookups in later cycles. A lookup in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_ibank | input | 1 | 1 selects the instruction bank, 0 the data bank |
| wr_hi | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_idx | input | IW | Entry index |
| wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_store | input | 1 | Request is a store (ignored on a fetch) |
| req_user | input | 1 | Request made in user state |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A usable entry matched |
| rsp_grant | output | 1 | Access granted by the block |
| rsp_violate | output | 1 | Entry matched but the right is missing |
| rsp_pass | output | 1 | Access goes on to segment translation |
| rsp_prot | output | 3 | Rights of the hit entry: [0] read, [1] write, [2] execute |
| rsp_ra | output | 32 | Real address |

## Verification
The bench targets these faults and what each one would show:
- Two usable entries cover the same address. A reversed priority returns the wrong real base.
- A supervisor-only entry shadows a user entry. A design that ignores the privilege bits hits the shadowed entry for user code.
- A partial length mask is tested with a differing bit just outside it. Masking the wrong bits turns the expected miss into a hit or corrupts the real address.
- A fetch and a load go to the same address with different banks. A swapped bank selection grants a fetch that has no execute right.
- A write coincides with a lookup. A design that forwards the write changes the same-cycle result.

// File: rtl/bat_xlate.sv
module bat_xlate #(
  parameter int N_ENT = 4,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ibank,
  input  logic          wr_hi,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          req_valid,
  input  logic          req_fetch,
  input  logic          req_store,
  input  logic          req_user,
  input  logic [31:0]   req_ea,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_grant,
  output logic          rsp_violate,
  output logic          rsp_pass,
  output logic [2:0]    rsp_prot,
  output logic [31:0]   rsp_ra
);

  logic [31:0] ibu [N_ENT];
  logic [31:0] ibl [N_ENT];
  logic [31:0] dbu [N_ENT];
  logic [31:0] dbl [N_ENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        ibu[i] <= '0;
        ibl[i] <= '0;
        dbu[i] <= '0;
        dbl[i] <= '0;
      end
    end else if (wr_en) begin
      case ({wr_ibank, wr_hi})
        2'b11:   ibu[wr_idx] <= wr_data;
        2'b10:   ibl[wr_idx] <= wr_data;
        2'b01:   dbu[wr_idx] <= wr_data;
        default: dbl[wr_idx] <= wr_data;
      endcase
    end
  end

  logic        found;
  logic [2:0]  prot;
  logic [31:0] ra;
  logic        right;

  always_comb begin
    logic [31:0] u, l;
    logic [10:0] len;
    logic        usable, match;
    found = 1'b0;
    prot  = 3'b000;
    ra    = req_ea;
    for (int i = 0; i < N_ENT; i++) begin
      u      = req_fetch ? ibu[i] : dbu[i];
      l      = req_fetch ? ibl[i] : dbl[i];
      len    = u[12:2];
      usable = req_user ? u[0] : u[1];
      match  = (req_ea[31:28] == u[31:28]) &&
               ((req_ea[27:17] & ~len) == u[27:17]);
      if (!found && usable && match) begin
        found = 1'b1;
        case (l[1:0])
          2'd0:    prot = 3'b000;
          2'd2:    prot = 3'b111;
          default: prot = 3'b101;
        endcase
        ra = {l[31:28], l[27:17] | (req_ea[27:17] & len), req_ea[16:0]};
      end
    end
  end

  assign right = req_fetch ? prot[2] : (req_store ? prot[1] : prot[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_grant   <= 1'b0;
      rsp_violate <= 1'b0;
      rsp_pass    <= 1'b0;
      rsp_prot    <= '0;
      rsp_ra      <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= req_valid && found;
      rsp_grant   <= req_valid && found && right;
      rsp_violate <= req_valid && found && !right;
      rsp_pass    <= req_valid && !(found && right);
      rsp_prot    <= prot;
      rsp_ra      <= ra;
    end
  end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_fetch,
  input logic          req_store,
  input logic [31:0]   req_ea,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_grant,
  input logic          rsp_violate,
  input logic          rsp_pass,
  input logic [2:0]    rsp_prot,
  input logic [31:0]   rsp_ra
);

  AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_hit && !rsp_pass);                                   // R8
  AST_HIT_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_grant != rsp_violate));                               // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_pass);                   // R9
  AST_NONE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && rsp_prot == 3'b000) |-> rsp_violate);                      // R4
  AST_WRITE_HAS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && rsp_prot[1]) |-> (rsp_prot == 3'b111));                    // R4
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ra[16:0] == $past(req_ea[16:0]));                    // R5
  AST_FETCH_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch) |=> (rsp_grant |-> rsp_prot[2]));             // R6
  AST_STORE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch && req_store) |=> (rsp_grant |-> rsp_prot[1])); // R6

endmodule

bind bat_xlate bat_xlate_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
  .req_store(req_store), .req_ea(req_ea), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_grant(rsp_grant), .rsp_violate(rsp_violate),
  .rsp_pass(rsp_pass), .rsp_prot(rsp_prot), .rsp_ra(rsp_ra)
);

// File: tb/bat_xlate_tb.sv
`timescale 1ns/1ps
module bat_xlate_tb;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_ibank = 0, wr_hi = 0;
  logic [1:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic req_valid = 0, req_fetch = 0, req_store = 0, req_user = 0;
  logic [31:0] req_ea = 0;
  logic rsp_valid, rsp_hit, rsp_grant, rsp_violate, rsp_pass;
  logic [2:0] rsp_prot;
  logic [31:0] rsp_ra;

  always #2 clk = ~clk;

  bat_xlate u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_iu [4], m_il [4], m_du [4], m_dl [4];

  bit e_v, e_h, e_g;
  logic [2:0] e_p;
  logic [31:0] e_ra;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] up(input logic [3:0] t, input logic [10:0] lo,
                                     input logic [10:0] len, input bit sv, input bit uv);
    return {t, lo, 4'b0, len, sv, uv};
  endfunction

  function automatic logic [31:0] low(input logic [3:0] t, input logic [10:0] lo, input logic [1:0] pp);
    return {t, lo, 15'b0, pp};
  endfunction

  task automatic model(input logic [31:0] ea, input bit f, input bit st, input bit u);
    logic [31:0] a, b, mask;
    bit need;
    e_h = 0; e_g = 0; e_p = 0; e_ra = ea;
    for (int i = 0; i < 4; i++) begin
      a = f ? m_iu[i] : m_du[i];
      b = f ? m_il[i] : m_dl[i];
      mask = {4'b0, a[12:2], 17'b0};
      if (!e_h && (u ? a[0] : a[1]) && (ea[31:28] == a[31:28]) &&
          ((ea & 32'h0FFE_0000 & ~mask) == (a & 32'h0FFE_0000))) begin
        e_h = 1;
        if (b[1:0] == 0) e_p = 3'b000;
        else if (b[1:0] == 2) e_p = 3'b111;
        else e_p = 3'b101;
        e_ra = (b & 32'hFFFE_0000) | (ea & mask) | (ea & 32'h0001_FFFF);
      end
    end
    need = f ? e_p[2] : (st ? e_p[1] : e_p[0]);
    e_g = e_h && need;
  endtask

  task automatic step();
    @(posedge clk); #1;
    chk(rsp_valid == e_v, "R9 valid", rsp_valid, e_v);
    if (e_v) begin
      chk(rsp_hit == e_h, e_tag, rsp_hit, e_h);
      chk(rsp_grant == e_g && rsp_violate == (e_h && !e_g), "R8 verdict",
          {rsp_grant, rsp_violate}, {e_g, e_h && !e_g});
      chk(rsp_pass == !e_g, "R8 pass", rsp_pass, !e_g);
      if (e_h) begin
        chk(rsp_prot == e_p, "R4 prot", rsp_prot, e_p);
        chk(rsp_ra == e_ra, "R5 ra", rsp_ra, e_ra);
      end
    end else
      chk(!rsp_hit && !rsp_grant && !rsp_pass, "R9 idle", {rsp_hit, rsp_grant, rsp_pass}, 0);
  endtask

  task automatic go(input bit we, input bit ib, input bit hi, input logic [1:0] idx,
                    input logic [31:0] d, input bit rv, input bit f, input bit st,
                    input bit u, input logic [31:0] ea, input string tag);
    wr_en = we; wr_ibank = ib; wr_hi = hi; wr_idx = idx; wr_data = d;
    req_valid = rv; req_fetch = f; req_store = st; req_user = u; req_ea = ea;
    e_v = rv; e_tag = tag;
    if (rv) model(ea, f, st, u);
    if (we) begin
      if (ib && hi) m_iu[idx] = d;
      else if (ib) m_il[idx] = d;
      else if (hi) m_du[idx] = d;
      else m_dl[idx] = d;
    end
    step();
    wr_en = 0; req_valid = 0;
  endtask

  task automatic wr(input bit ib, input bit hi, input logic [1:0] idx, input logic [31:0] d);
    go(1, ib, hi, idx, d, 0, 0, 0, 0, 0, "R9 idle");
  endtask

  task automatic rd(input bit f, input bit st, input bit u, input logic [31:0] ea, input string tag);
    go(0, 0, 0, 0, 0, 1, f, st, u, ea, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_iu[i] = 0; m_il[i] = 0; m_du[i] = 0; m_dl[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(rsp_valid == 0 && rsp_hit == 0, "R10 reset", {rsp_valid, rsp_hit}, 0);
    rd(0, 0, 0, 32'h0000_0000, "R10 empty miss");
    chk(!rsp_hit && rsp_pass, "R10 empty", {rsp_hit, rsp_pass}, 2'b01);

    wr(0, 1, 0, up(4'h1, 0, 0, 1, 0));       wr(0, 0, 0, low(4'h3, 11'h001, 2));
    wr(0, 1, 1, up(4'h1, 0, 0, 1, 1));       wr(0, 0, 1, low(4'h5, 0, 1));
    wr(0, 1, 2, up(4'h8, 0, 11'h7FF, 1, 1)); wr(0, 0, 2, low(4'hC, 0, 3));
    wr(0, 1, 3, up(4'h4, 11'h7F0, 11'h00F, 1, 0)); wr(0, 0, 3, low(4'h6, 11'h550, 2));
    wr(1, 1, 0, up(4'h1, 0, 0, 1, 1));       wr(1, 0, 0, low(4'h9, 0, 0));

    rd(0, 0, 0, 32'h1001_2345, "R7 priority");
    chk(rsp_ra == 32'h3003_2345 && rsp_grant, "R7 lowest wins", rsp_ra, 32'h3003_2345);
    rd(0, 0, 1, 32'h1001_2345, "R3 user skips sup-only");
    chk(rsp_ra == 32'h5001_2345 && rsp_prot == 3'b101, "R3 user entry", rsp_ra, 32'h5001_2345);
    rd(0, 1, 1, 32'h1001_2345, "R8 store denied");
    chk(rsp_violate && rsp_pass, "R8 denied passes on", {rsp_violate, rsp_pass}, 2'b11);
    rd(0, 0, 0, 32'h8ABC_D123, "R5 full mask");
    chk(rsp_ra == 32'hCABC_D123, "R5 full mask ra", rsp_ra, 32'hCABC_D123);
    rd(0, 0, 0, 32'h4FE6_0ABC, "R2 partial mask hit");
    chk(rsp_hit && rsp_ra == 32'h6AA6_0ABC, "R2 partial ra", rsp_ra, 32'h6AA6_0ABC);
    rd(0, 0, 0, 32'h4FC6_0ABC, "R2 compared bit differs");
    chk(!rsp_hit, "R2 miss", rsp_hit, 0);
    rd(0, 0, 0, 32'h2001_2345, "R1 top nibble");
    chk(!rsp_hit && rsp_pass, "R1 miss", rsp_hit, 0);
    rd(1, 0, 0, 32'h1001_2345, "R6 fetch uses ibank");
    chk(rsp_hit && rsp_violate && rsp_ra == 32'h9001_2345, "R6 fetch", rsp_ra, 32'h9001_2345);
    rd(0, 0, 1, 32'h4FE6_0ABC, "R3 user invalid");
    chk(!rsp_hit, "R3 user miss", rsp_hit, 0);

    go(1, 0, 0, 0, low(4'h3, 11'h001, 0), 1, 0, 0, 0, 32'h1001_2345, "R10 same-cycle write");
    chk(rsp_grant, "R10 old contents", rsp_grant, 1);
    rd(0, 0, 0, 32'h1001_2345, "R10 write visible");
    chk(rsp_violate && rsp_prot == 0, "R10 new contents", rsp_prot, 0);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (n % 3 == 0) begin
        logic [31:0] d;
        d = $urandom;
        d[31:30] = 0;
        go(1, r[0], r[1], r[3:2], d, r[4], r[5], r[6], r[7],
           {2'b0, r[31:8], 6'b0}, "R7 random");
      end else
        rd(r[0], r[1], r[2], {2'b0, r[31:5], r[4:3], 1'b0}, "R7 random");
    end
    go(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule